// File: doc/BRIEF.md
# Anti-Aliasing Sub-Sample Accumulator

This block sums several anti-aliasing sub-samples of the same pixel for a small screen tile. When the last sub-sample arrives, it produces the averaged 8-bit colour for the frame buffer. Each incoming sample carries:

- a pixel index within the tile;
- 8-bit red, green, blue and alpha components;
- its own sample number, counting from zero;
- the total number of sub-samples for that pixel.

The block keeps one wide accumulator word per pixel, with 16 bits per component. A single adder per component folds each new sample into the stored sum. Sample number zero replaces whatever the word held before.

A mode input selects how the final average is formed:

- Divide mode uses a true divider, so any count from 1 to 256 works.
- Shift mode uses a variable right shift. This is only valid when the count is a power of two. Any other count raises an error pulse and produces no colour.

The pixel-memory read is registered. A sample that follows its predecessor to the same pixel on the very next cycle therefore takes the freshly computed sum from a bypass register and not from the memory.

Top module: `vab_accum_alu`

## Requirements
- R1: After reset, out_valid and out_err are 0 until a final sub-sample has been processed.
- R2: A sample with sample number 0 replaces the pixel's stored sum with its own components, whatever the pixel held before.
- R3: A sample with a non-zero number adds its components to the 16-bit stored sum; 256 samples of value 255 average to exactly 255.
- R4: A sample is final when its number equals count minus 1. The average for it appears on out_valid, with out_pix, on the second rising edge after the sample is accepted.
- R5: With in_shift_mode = 0, each output component is the floor of the component sum divided by the count, for any count from 1 to 256.
- R6: With in_shift_mode = 1 and a power-of-two count, each output component is the sum shifted right by log2(count).
- R7: With in_shift_mode = 1 and a final sample whose count is not a power of two, out_err pulses for one cycle at the moment the average would have appeared, and out_valid stays 0.
- R8: Samples that are not final produce no output, and a count of 0 never completes.
- R9: Back-to-back samples to the same pixel on consecutive cycles accumulate correctly.
- R10: The average is not written back. The stored sum keeps the full total, so a later non-zero sample with a larger count continues from that total.
- R11: Pixels accumulate independently when their samples are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_pix | input | PIX_AW | Pixel index within the tile |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| in_a | input | 8 | Alpha component |
| in_idx | input | 8 | Sample number, 0 = first |
| in_cnt | input | 9 | Total sub-samples for the pixel, 1..256 |
| in_shift_mode | input | 1 | 1 = average by shift, 0 = by division |
| out_valid | output | 1 | Averaged colour is valid |
| out_pix | output | PIX_AW | Pixel index of the averaged colour |
| out_r | output | 8 | Averaged red |
| out_g | output | 8 | Averaged green |
| out_b | output | 8 | Averaged blue |
| out_a | output | 8 | Averaged alpha |
| out_err | output | 1 | Shift mode was asked for with a non-power-of-two count |

## Verification
The hardest case to reach is the read-after-write hazard. It needs a second sample to the same pixel on the cycle right after the first, so that the registered memory read still returns the stale sum. The stimulus reaches it by driving gap-free bursts to one pixel and then interleaving two pixels. With the bursts, every sample after the first depends on the bypass. With the interleaving, the bypass must not be taken. Overwrite on sample zero and the missing write-back of the average are shown by re-using pixels that already hold sums. The bench then compares each output against a reference model computed separately in the bench.

// File: rtl/vab_pkg.sv
package vab_pkg;
    localparam int NCH   = 4;   // components per pixel: 0 red, 1 green, 2 blue, 3 alpha
    localparam int IN_W  = 8;   // incoming component width
    localparam int ACC_W = 16;  // accumulator component width
    localparam int IDX_W = 8;   // sample number width
    localparam int CNT_W = 9;   // sample count width (up to 256)

    typedef logic [NCH-1:0][IN_W-1:0]  px8_t;
    typedef logic [NCH-1:0][ACC_W-1:0] pxacc_t;
endpackage

// File: rtl/vab_acc_mem.sv
module vab_acc_mem #(
    parameter int AW = 6,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_q;

    // registered read, old data on a same-cycle write (hazard resolved by caller)
    always_ff @(posedge clk) begin
        rd_q <= mem_q[rd_addr];
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/vab_lane_add.sv
module vab_lane_add #(
    parameter int IN_W  = 8,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             first,
    input  logic [IN_W-1:0]  samp,
    input  logic [ACC_W-1:0] operand,
    output logic [ACC_W-1:0] sum
);
    localparam int PAD = ACC_W + 1 - IN_W;

    logic [ACC_W:0] wide;

    always_comb begin
        if (first) begin
            wide = {{PAD{1'b0}}, samp};
        end else begin
            wide = {1'b0, operand} + {{PAD{1'b0}}, samp};
        end
    end

    assign sum = wide[ACC_W-1:0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> !wide[ACC_W]); // R3
endmodule

// File: rtl/vab_scaler.sv
module vab_scaler
    import vab_pkg::*;
(
    input  pxacc_t           sum,
    input  logic [CNT_W-1:0] cnt,
    input  logic             shift_mode,
    output px8_t             avg,
    output logic             is_pow2
);
    localparam int SH_W = $clog2(CNT_W);

    logic [SH_W-1:0]  sh_amt;
    logic [CNT_W-1:0] safe_cnt;

    always_comb begin
        sh_amt = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (cnt[i]) sh_amt = SH_W'(i);
        end
        is_pow2  = (cnt != '0) && ((cnt & (cnt - CNT_W'(1))) == '0);
        safe_cnt = (cnt == '0) ? CNT_W'(1) : cnt;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic [ACC_W-1:0] q_div;
        logic [ACC_W-1:0] q_shf;
        always_comb begin
            q_div = sum[c] / ACC_W'(safe_cnt);
            q_shf = sum[c] >> sh_amt;
            avg[c] = shift_mode ? q_shf[IN_W-1:0] : q_div[IN_W-1:0];
        end
    end
endmodule

// File: rtl/vab_accum_alu.sv
module vab_accum_alu
    import vab_pkg::*;
#(
    parameter int PIX_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_AW-1:0] in_pix,
    input  logic [7:0]        in_r,
    input  logic [7:0]        in_g,
    input  logic [7:0]        in_b,
    input  logic [7:0]        in_a,
    input  logic [7:0]        in_idx,
    input  logic [8:0]        in_cnt,
    input  logic              in_shift_mode,
    output logic              out_valid,
    output logic [PIX_AW-1:0] out_pix,
    output logic [7:0]        out_r,
    output logic [7:0]        out_g,
    output logic [7:0]        out_b,
    output logic [7:0]        out_a,
    output logic              out_err
);
    localparam int WORD_W = NCH * ACC_W;

    typedef struct packed {
        logic              s_vld;
        logic [PIX_AW-1:0] s_pix;
        px8_t              s_samp;
        logic              s_first;
        logic              s_last;
        logic              s_shift;
        logic [CNT_W-1:0]  s_cnt;
        logic              w_vld;
        logic [PIX_AW-1:0] w_pix;
        pxacc_t            w_acc;
        logic              o_vld;
        logic [PIX_AW-1:0] o_pix;
        px8_t              o_rgba;
        logic              o_err;
    } state_t;

    state_t st_d, st_q;

    pxacc_t        rd_word;
    logic [WORD_W-1:0] rd_raw;
    pxacc_t        operand;
    pxacc_t        sum;
    px8_t          avg;
    logic          is_pow2;
    logic          use_fwd;
    logic          final_bad;

    vab_acc_mem #(.AW(PIX_AW), .DW(WORD_W)) u_mem (
        .clk     (clk),
        .rd_addr (in_pix),
        .rd_data (rd_raw),
        .wr_en   (st_q.s_vld),
        .wr_addr (st_q.s_pix),
        .wr_data (sum)
    );

    assign rd_word = rd_raw;

    // forward the sum written on the previous edge when the memory read raced it
    assign use_fwd = st_q.w_vld && (st_q.w_pix == st_q.s_pix);
    assign operand = use_fwd ? st_q.w_acc : rd_word;

    for (genvar c = 0; c < NCH; c++) begin : g_add
        vab_lane_add #(.IN_W(IN_W), .ACC_W(ACC_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld     (st_q.s_vld),
            .first   (st_q.s_first),
            .samp    (st_q.s_samp[c]),
            .operand (operand[c]),
            .sum     (sum[c])
        );
    end

    vab_scaler u_scale (
        .sum        (sum),
        .cnt        (st_q.s_cnt),
        .shift_mode (st_q.s_shift),
        .avg        (avg),
        .is_pow2    (is_pow2)
    );

    assign final_bad = st_q.s_shift && !is_pow2;

    always_comb begin
        st_d = st_q;
        // input stage
        st_d.s_vld     = in_valid;
        st_d.s_pix     = in_pix;
        st_d.s_samp    = {in_a, in_b, in_g, in_r};
        st_d.s_first   = (in_idx == '0);
        st_d.s_last    = (in_cnt != '0) && ({1'b0, in_idx} == (in_cnt - CNT_W'(1)));
        st_d.s_shift   = in_shift_mode;
        st_d.s_cnt     = in_cnt;
        // bypass copy of the word being written
        st_d.w_vld     = st_q.s_vld;
        st_d.w_pix     = st_q.s_pix;
        st_d.w_acc     = sum;
        // result stage
        st_d.o_vld     = st_q.s_vld && st_q.s_last && !final_bad;
        st_d.o_err     = st_q.s_vld && st_q.s_last && final_bad;
        st_d.o_pix     = st_q.s_pix;
        st_d.o_rgba    = avg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_vld;
    assign out_err   = st_q.o_err;
    assign out_pix   = st_q.o_pix;
    assign out_r     = st_q.o_rgba[0];
    assign out_g     = st_q.o_rgba[1];
    assign out_b     = st_q.o_rgba[2];
    assign out_a     = st_q.o_rgba[3];

    AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_err) |-> $past(in_valid, 2)); // R4
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> !out_valid); // R7
    AST_ERR_SHIFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $past(in_shift_mode, 2)); // R7
    AST_ZERO_COUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cnt == '0) |=> !st_q.s_last); // R8
endmodule

// File: tb/vab_accum_alu_test.sv
module vab_accum_alu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] in_pix = '0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0, in_a = '0;
    logic [7:0] in_idx = '0;
    logic [8:0] in_cnt = '0;
    logic       in_shift_mode = 1'b0;
    logic       out_valid, out_err;
    logic [5:0] out_pix;
    logic [7:0] out_r, out_g, out_b, out_a;

    always #10 clk = ~clk;

    vab_accum_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_a(in_a),
        .in_idx(in_idx), .in_cnt(in_cnt), .in_shift_mode(in_shift_mode),
        .out_valid(out_valid), .out_pix(out_pix),
        .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_a(out_a),
        .out_err(out_err)
    );

    typedef struct {
        bit    err;
        int    pix;
        int    c[4];
        string tag;
    } exp_t;

    exp_t q[$];
    int   acc[64][4];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: reference model plus queue push
    task automatic send(input int pix, input int r, input int g, input int b, input int a,
                        input int idx, input int cnt, input bit shf, input string tag);
        int v[4];
        exp_t e;
        v[0] = r; v[1] = g; v[2] = b; v[3] = a;
        for (int c = 0; c < 4; c++) begin
            if (idx == 0) acc[pix][c] = v[c];
            else          acc[pix][c] = acc[pix][c] + v[c];
        end
        if (cnt != 0 && idx == cnt - 1) begin
            e.pix = pix;
            e.tag = tag;
            e.err = shf && ((cnt & (cnt - 1)) != 0);
            for (int c = 0; c < 4; c++) e.c[c] = acc[pix][c] / cnt;
            q.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b1; in_pix = 6'(pix);
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b); in_a = 8'(a);
        in_idx = 8'(idx); in_cnt = 9'(cnt); in_shift_mode = shf;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && (out_valid || out_err)) begin
            exp_t e;
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R8: unexpected output pix=%0d valid=%0b err=%0b, expected none",
                         out_pix, out_valid, out_err);
            end else begin
                e = q.pop_front();
                if (e.err) begin
                    if (!(out_err && !out_valid)) begin
                        n_bad++;
                        $display("FAIL %s: err=%0b valid=%0b, expected err=1 valid=0",
                                 e.tag, out_err, out_valid);
                    end
                end else if (!(out_valid && !out_err && out_pix == 6'(e.pix) &&
                               out_r == 8'(e.c[0]) && out_g == 8'(e.c[1]) &&
                               out_b == 8'(e.c[2]) && out_a == 8'(e.c[3]))) begin
                    n_bad++;
                    $display("FAIL %s: got v=%0b e=%0b pix=%0d %0d/%0d/%0d/%0d, expected pix=%0d %0d/%0d/%0d/%0d",
                             e.tag, out_valid, out_err, out_pix, out_r, out_g, out_b, out_a,
                             e.pix, e.c[0], e.c[1], e.c[2], e.c[3]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        n_chk++;
        if (out_valid !== 1'b0 || out_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid=%0b err=%0b, expected 0/0", out_valid, out_err);
        end

        // R5/R9: divide by 4, gap-free to one pixel
        send(3, 10, 20, 30, 40, 0, 4, 0, "R9");
        send(3, 11, 21, 31, 41, 1, 4, 0, "R9");
        send(3, 12, 22, 32, 42, 2, 4, 0, "R9");
        send(3, 13, 23, 33, 255, 3, 4, 0, "R9");
        idle(3);

        // R5: divide by 3, spaced samples
        send(7, 100, 0, 255, 1, 0, 3, 0, "R5"); idle(2);
        send(7, 101, 0, 255, 1, 1, 3, 0, "R5"); idle(2);
        send(7, 103, 1, 254, 1, 2, 3, 0, "R5"); idle(3);

        // R5: count 1
        send(9, 77, 88, 99, 5, 0, 1, 0, "R5"); idle(3);

        // R6: shift by 8
        for (int i = 0; i < 8; i++) send(12, 200 + i, i * 30, 17, 250, i, 8, 1, "R6");
        idle(3);

        // R7: shift mode with count 6
        for (int i = 0; i < 6; i++) send(13, 50, 60, 70, 80, i, 6, 1, "R7");
        idle(3);

        // R3: 256 full-scale samples, shift and divide
        for (int i = 0; i < 256; i++) send(20, 255, 255, 255, 255, i, 256, 1, "R3");
        idle(2);
        for (int i = 0; i < 256; i++) send(21, 255, 254, 1, 0, i, 256, 0, "R3");
        idle(3);

        // R11: interleaved pixels
        for (int i = 0; i < 5; i++) begin
            send(30, 10 * i, 3, 90, 7 + i, i, 5, 0, "R11");
            send(31, 40, 2 * i, 5, 200, i, 5, 0, "R11");
        end
        idle(3);

        // R2: pixel 3 already holds a sum; sample zero replaces it
        send(3, 1, 2, 3, 4, 0, 2, 0, "R2");
        send(3, 5, 6, 7, 8, 1, 2, 0, "R2");
        idle(3);

        // R10: continue pixel 3 from its full total with a larger count
        send(3, 9, 9, 9, 9, 2, 3, 0, "R10");
        idle(3);

        // R8: count 0 and non-final samples give nothing
        send(40, 1, 1, 1, 1, 0, 0, 0, "R8");
        send(40, 1, 1, 1, 1, 1, 0, 0, "R8");
        send(41, 9, 9, 9, 9, 0, 4, 0, "R8");
        idle(5);
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R8: %0d outputs missing, expected 0", q.size());
        end
        report();
    end
endmodule